// File: doc/BRIEF.md
# Frame Interrupt and Floating Bus Unit

This block keeps the raster position of a video frame in half-cycle steps and derives two CPU-facing signals from it. The first is a once-per-frame interrupt pulse, placed a fixed distance ahead of the first display fetch of the next frame. The second is the byte that a read of an unmapped port sees: the "floating" bus.

The floating bus value depends on where the raster is. Outside the display lines it is all ones. Inside the display lines there are two cases:
- During an active fetch slot it is one of the four bytes latched by the most recent video fetch burst.
- Between slots, and past the end of the display span, it is the byte of the last contended access.

The last-access byte is held in a register. That register loads from CPU memory traffic on a strobe, and from the closing attribute byte of every fetch burst. A mode input selects the later-model behaviour, in which bit 0 of every value taken from either path is forced high.

The clock is the half-cycle tick. Position 0 of the frame is the first video fetch of line 0.

Top module: `frame_irq_fbus`

## Requirements
- R1: After reset the frame position is 0, which is line 0, column 0. The position advances by one on every clock. Columns wrap at LINE_HC and lines wrap at FRAME_LINES, so the frame repeats every LINE_HC*FRAME_LINES clocks.
- R2: `irq_o` is high exactly while the frame position lies in [IRQ_START, IRQ_START+IRQ_LEN_HC), where IRQ_START = LINE_HC*FRAME_LINES - IRQ_LEAD_HC. With the default values this window is positions 113080 to 113127.
- R3: `irq_o` is driven by a flop. It is low during and right after reset, and changes only at clock edges.
- R4: On lines numbered DISP_LINES and above, `fbus_o` is 0xFF.
- R5: On display lines, `fbus_o` equals the last-access byte when the column is DISP_HC or more, or when column bit 3 is 1.
- R6: Otherwise `fbus_o` equals fetch byte k, where k = column bits [2:1]. Byte k occupies bits [8k+7:8k] of `fetch_bytes_i`.
- R7: When `late_mode_i` is 1, bit 0 of a fetch byte shown on `fbus_o` reads as 1. The other bits are unchanged.
- R8: A clock with `mem_strobe_i` high loads `mem_data_i` into the last-access byte. When `late_mode_i` is 1, bit 0 is forced to 1.
- R9: A clock with `burst_done_i` high and `mem_strobe_i` low loads fetch byte 3 into the last-access byte, with the same bit 0 forcing. When both inputs are high, `mem_strobe_i` wins.
- R10: The last-access byte resets to 0xFF and holds its value on clocks with neither load input high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cycle clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| late_mode_i | input | 1 | Selects later-model bit 0 forcing |
| fetch_bytes_i | input | 32 | Latched fetch burst; byte k at [8k+7:8k] |
| burst_done_i | input | 1 | Fetch burst complete; load byte 3 as the last access |
| mem_strobe_i | input | 1 | Contended memory access strobe |
| mem_data_i | input | 8 | Data of the contended access |
| irq_o | output | 1 | Frame interrupt |
| fbus_o | output | 8 | Floating bus byte |

## Verification
The embedded assertions check the following on every cycle:
- the column and line counters agree with the linear frame position, and the position wraps correctly;
- the interrupt rises and falls only at the exact compare positions;
- the border lines read 0xFF;
- bit 0 is forced on the later-model paths.

Only the bench scenarios can show the rest:
- the choice of fetch byte per slot;
- the priority of the memory strobe over the burst load;
- the value the last-access register holds across idle cycles, including its reset value;
- the mode changing between frames.

The bench does this by sweeping whole frames of a reduced geometry and checking every output on every clock against arithmetic expectations.

// File: rtl/frame_irq_fbus_pkg.sv
package frame_irq_fbus_pkg;
  typedef logic [7:0] byte_t;

  localparam int unsigned SLOTS = 4;

  function automatic byte_t force_bit0(input byte_t b, input logic en);
    return {b[7:1], b[0] | en};
  endfunction
endpackage

// File: rtl/frame_pos_counter.sv
module frame_pos_counter #(
  parameter int unsigned LINE_HC     = 456,
  parameter int unsigned FRAME_LINES = 311,
  localparam int unsigned FRAME_HC   = LINE_HC * FRAME_LINES,
  localparam int unsigned COL_W      = $clog2(LINE_HC),
  localparam int unsigned LINE_W     = $clog2(FRAME_LINES),
  localparam int unsigned POS_W      = $clog2(FRAME_HC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [COL_W-1:0]  col_o,
  output logic [LINE_W-1:0] line_o,
  output logic [POS_W-1:0]  pos_o,
  output logic [POS_W-1:0]  pos_next_o
);
  logic [COL_W-1:0]  col_q, col_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic              col_wrap, line_wrap;

  assign col_wrap  = (col_q == COL_W'(LINE_HC - 1));
  assign line_wrap = (line_q == LINE_W'(FRAME_LINES - 1));

  always_comb begin
    col_d  = col_wrap ? '0 : col_q + 1'b1;
    line_d = line_q;
    if (col_wrap) line_d = line_wrap ? '0 : line_q + 1'b1;
    pos_d  = (pos_q == POS_W'(FRAME_HC - 1)) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      line_q <= '0;
      pos_q  <= '0;
    end else begin
      col_q  <= col_d;
      line_q <= line_d;
      pos_q  <= pos_d;
    end
  end

  assign col_o      = col_q;
  assign line_o     = line_q;
  assign pos_o      = pos_q;
  assign pos_next_o = pos_d;

  assert_pos_consistent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pos_q) == int'(line_q) * int'(LINE_HC) + int'(col_q));

  assert_pos_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == POS_W'(FRAME_HC - 1)) |=> (pos_q == '0 && col_q == '0 && line_q == '0));
endmodule

// File: rtl/frame_irq_gen.sv
module frame_irq_gen #(
  parameter int unsigned POS_W     = 18,
  parameter int unsigned IRQ_START = 113080,
  parameter int unsigned IRQ_LEN   = 48,
  localparam int unsigned IRQ_END  = IRQ_START + IRQ_LEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] pos_next_i,
  output logic             irq_o
);
  logic irq_q;

  // exact compares on the upcoming position keep irq aligned with pos_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               irq_q <= 1'b0;
    else if (pos_next_i == POS_W'(IRQ_START))  irq_q <= 1'b1;
    else if (pos_next_i == POS_W'(IRQ_END))    irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  assert_irq_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> (pos_i == POS_W'(IRQ_START)));

  assert_irq_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> (pos_i == POS_W'(IRQ_END)));

  assert_irq_reset_low_R3: assert property (@(posedge clk_i)
    !rst_ni |-> !irq_q);
endmodule

// File: rtl/last_access_reg.sv
module last_access_reg
  import frame_irq_fbus_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  late_mode_i,
  input  logic  mem_strobe_i,
  input  byte_t mem_data_i,
  input  logic  burst_done_i,
  input  byte_t burst_last_i,
  output byte_t last_o
);
  byte_t last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           last_q <= 8'hFF;
    else if (mem_strobe_i) last_q <= force_bit0(mem_data_i, late_mode_i);
    else if (burst_done_i) last_q <= force_bit0(burst_last_i, late_mode_i);
  end

  assign last_o = last_q;

  assert_late_bit0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_mode_i && (mem_strobe_i || burst_done_i)) |=> last_q[0]);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_strobe_i && !burst_done_i) |=> $stable(last_q));
endmodule

// File: rtl/fbus_mux.sv
module fbus_mux
  import frame_irq_fbus_pkg::*;
#(
  parameter int unsigned COL_W      = 9,
  parameter int unsigned LINE_W     = 9,
  parameter int unsigned DISP_LINES = 192,
  parameter int unsigned DISP_HC    = 256
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  late_mode_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [LINE_W-1:0]     line_i,
  input  logic [8*SLOTS-1:0]    fetch_bytes_i,
  input  byte_t                 last_i,
  output byte_t                 fbus_o
);
  logic  on_disp_line, in_fetch;
  logic [1:0] slot;
  byte_t slot_bytes [SLOTS];
  byte_t fetch_sel;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign slot_bytes[k] = fetch_bytes_i[8*k +: 8];
  end

  assign on_disp_line = (line_i < LINE_W'(DISP_LINES));
  assign in_fetch     = (col_i < COL_W'(DISP_HC)) && !col_i[3];
  assign slot         = col_i[2:1];
  assign fetch_sel    = force_bit0(slot_bytes[slot], late_mode_i);

  always_comb begin
    if (!on_disp_line)  fbus_o = 8'hFF;
    else if (!in_fetch) fbus_o = last_i;
    else                fbus_o = fetch_sel;
  end

  assert_border_ff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i >= LINE_W'(DISP_LINES)) |-> (fbus_o == 8'hFF));

  assert_gap_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((line_i < LINE_W'(DISP_LINES)) && col_i[3]) |-> (fbus_o == last_i));

  assert_late_fetch_bit0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_mode_i && (line_i < LINE_W'(DISP_LINES)) && (col_i < COL_W'(DISP_HC)) && !col_i[3])
      |-> fbus_o[0]);
endmodule

// File: rtl/frame_irq_fbus.sv
module frame_irq_fbus
  import frame_irq_fbus_pkg::*;
#(
  parameter int unsigned LINE_HC     = 456,
  parameter int unsigned FRAME_LINES = 311,
  parameter int unsigned DISP_LINES  = 192,
  parameter int unsigned DISP_HC     = 256,
  parameter int unsigned IRQ_LEAD_HC = 28736,
  parameter int unsigned IRQ_LEN_HC  = 48,
  localparam int unsigned FRAME_HC   = LINE_HC * FRAME_LINES,
  localparam int unsigned IRQ_START  = FRAME_HC - IRQ_LEAD_HC,
  localparam int unsigned COL_W      = $clog2(LINE_HC),
  localparam int unsigned LINE_W     = $clog2(FRAME_LINES),
  localparam int unsigned POS_W      = $clog2(FRAME_HC)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        late_mode_i,
  input  logic [31:0] fetch_bytes_i,
  input  logic        burst_done_i,
  input  logic        mem_strobe_i,
  input  logic [7:0]  mem_data_i,
  output logic        irq_o,
  output logic [7:0]  fbus_o
);
  logic [COL_W-1:0]  col;
  logic [LINE_W-1:0] line;
  logic [POS_W-1:0]  pos, pos_next;
  byte_t             last_byte;

  frame_pos_counter #(
    .LINE_HC     (LINE_HC),
    .FRAME_LINES (FRAME_LINES)
  ) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .col_o      (col),
    .line_o     (line),
    .pos_o      (pos),
    .pos_next_o (pos_next)
  );

  frame_irq_gen #(
    .POS_W     (POS_W),
    .IRQ_START (IRQ_START),
    .IRQ_LEN   (IRQ_LEN_HC)
  ) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pos_i      (pos),
    .pos_next_i (pos_next),
    .irq_o      (irq_o)
  );

  last_access_reg u_last (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .late_mode_i  (late_mode_i),
    .mem_strobe_i (mem_strobe_i),
    .mem_data_i   (mem_data_i),
    .burst_done_i (burst_done_i),
    .burst_last_i (fetch_bytes_i[31:24]),
    .last_o       (last_byte)
  );

  fbus_mux #(
    .COL_W      (COL_W),
    .LINE_W     (LINE_W),
    .DISP_LINES (DISP_LINES),
    .DISP_HC    (DISP_HC)
  ) u_mux (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .late_mode_i   (late_mode_i),
    .col_i         (col),
    .line_i        (line),
    .fetch_bytes_i (fetch_bytes_i),
    .last_i        (last_byte),
    .fbus_o        (fbus_o)
  );
endmodule

// File: tb/frame_irq_fbus_tb.sv
module frame_irq_fbus_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int LINE_HC     = 64;
  localparam int FRAME_LINES = 10;
  localparam int DISP_LINES  = 6;
  localparam int DISP_HC     = 32;
  localparam int IRQ_LEAD_HC = 100;
  localparam int IRQ_LEN_HC  = 12;
  localparam int FRAME_HC    = LINE_HC * FRAME_LINES;
  localparam int IRQ_START   = FRAME_HC - IRQ_LEAD_HC;
  localparam int N_FRAMES    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        late_mode = 1'b0;
  logic [31:0] fetch_bytes = '0;
  logic        burst_done = 1'b0;
  logic        mem_strobe = 1'b0;
  logic [7:0]  mem_data = '0;
  logic        irq;
  logic [7:0]  fbus;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  frame_irq_fbus #(
    .LINE_HC     (LINE_HC),
    .FRAME_LINES (FRAME_LINES),
    .DISP_LINES  (DISP_LINES),
    .DISP_HC     (DISP_HC),
    .IRQ_LEAD_HC (IRQ_LEAD_HC),
    .IRQ_LEN_HC  (IRQ_LEN_HC)
  ) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .late_mode_i   (late_mode),
    .fetch_bytes_i (fetch_bytes),
    .burst_done_i  (burst_done),
    .mem_strobe_i  (mem_strobe),
    .mem_data_i    (mem_data),
    .irq_o         (irq),
    .fbus_o        (fbus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int n, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %02h expected %02h", req, n, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int n, input int k);
    return 8'((n * 37 + k * 91 + 3) & 255);
  endfunction

  initial begin
    logic [7:0] last_exp;
    last_exp = 8'hFF;
    #(CLK_PERIOD * 2 + 2);
    // reset state (R3, R10)
    check("R3", -1, {7'd0, irq}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < N_FRAMES * FRAME_HC; n++) begin
      int pos, line, col;
      logic [7:0] exp_fb, byte_sel;
      logic exp_irq;
      if (n != 0) @(negedge clk);
      late_mode   = ((n / FRAME_HC) % 2) == 1;
      fetch_bytes = {fbyte(n, 3), fbyte(n, 2), fbyte(n, 1), fbyte(n, 0)};
      // keep the load inputs quiet for the first 24 cycles so the reset value shows
      burst_done  = (n >= 24) && (n % 8 == 7);
      mem_strobe  = (n >= 24) && (n % 13 == 5);
      mem_data    = 8'((n * 53 + 10) & 254);
      #1;
      pos  = n % FRAME_HC;
      line = pos / LINE_HC;
      col  = pos % LINE_HC;
      exp_irq = (pos >= IRQ_START) && (pos < IRQ_START + IRQ_LEN_HC);
      check((pos == IRQ_START || pos == IRQ_START + IRQ_LEN_HC) ? "R2 edge" : "R1/R2",
            n, {7'd0, irq}, {7'd0, exp_irq});
      if (line >= DISP_LINES) begin
        exp_fb = 8'hFF;
        check("R4", n, fbus, exp_fb);
      end else if (col >= DISP_HC || ((col >> 3) & 1) == 1) begin
        exp_fb = last_exp;
        check((n < 24) ? "R10 reset" : "R5/R8/R9", n, fbus, exp_fb);
      end else begin
        byte_sel = fbyte(n, (col >> 1) & 3);
        exp_fb = late_mode ? (byte_sel | 8'h01) : byte_sel;
        check(late_mode ? "R7" : "R6", n, fbus, exp_fb);
      end
      // register update at the coming edge: strobe has priority (R8, R9)
      if (mem_strobe)      last_exp = late_mode ? (mem_data | 8'h01) : mem_data;
      else if (burst_done) last_exp = late_mode ? (fbyte(n, 3) | 8'h01) : fbyte(n, 3);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule